// File: doc/BRIEF.md
# SPI Master/Slave Controller

A byte-wide serial peripheral interface controller that works either as the bus master, generating the serial clock, or as a slave clocked from outside. The role, clock phase, clock polarity, clock rate and interrupt enable are set through a control register on a small CPU bus. A completion flag and a write-collision flag live in a status register. A single data address both starts a transfer (write) and returns the last received byte (read).

Every exchange is a full-duplex, MSB-first swap of eight bits. The pads are not part of the block. Each serial pin is described by an input, plus an output value and an output enable where the block may drive it. A master that honours its select input gives up the bus as soon as that input is pulled low, so two masters on one bus cannot fight. A slave protects a byte that is in flight by refusing CPU writes to it.

Top module: `spi_duplex_ctrl`

## Requirements
- R1: With the enable bit (control bit 0) clear, `sclk_oe`, `mosi_oe` and `miso_oe` stay 0 and a write to the data address starts no transfer and sets no flag.
- R2: As a slave with select honoured (control bit 1 = 0, bit 2 = 0), `miso_oe` is 1 while `ss_in` is low and 0 while it is high.
- R3: As a master with select honoured (bit 1 = 0, bit 2 = 1), a low `ss_in` clears control bit 2 in hardware within three clock cycles, and the block then behaves as a slave.
- R4: As a master with select honoured, `mosi_oe` and `sclk_oe` are 1 only while a byte is being shifted. While idle, `sclk_out` equals the polarity bit (control bit 4).
- R5: With ignore-select set (bit 1 = 1), control bit 2 alone picks the role and `ss_in` has no effect. A master drives `mosi_oe` and `sclk_oe` permanently and a slave drives `miso_oe` permanently.
- R6: A master transfer starts on a write to address 2. The first SCLK edge follows 2<<D system cycles after the write cycle, and later edges are 2<<D cycles apart, where D is control bits 6:5. This gives an SCLK period of 4<<D cycles.
- R7: Transfers are MSB first and full duplex. With phase bit 3 = 0, data is sampled on the leading SCLK edge (the edge that leaves the idle level). With phase = 1, it is sampled on the trailing edge. A read of address 2 returns the received byte.
- R8: After its 16th SCLK edge, a master stops SCLK and sets the completion flag (status bit 0). `irq` equals that flag ANDed with control bit 7.
- R9: As a slave with phase 0 and selected, a write to address 2 leaves the byte to be sent unchanged and sets the collision flag (status bit 1).
- R10: As a slave with phase 1, `ss_in` may stay low across consecutive bytes. Each byte completes, and sets the completion flag, on its 8th trailing edge, and the next byte may be written between bytes without a collision.
- R11: Both status flags are sticky. Writing 1 to a status bit at address 1 clears only that bit.
- R12: A write to address 2 while a master transfer is running is ignored and sets the collision flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| bus_wr | input | 1 | CPU write strobe |
| bus_addr | input | 2 | Register address: 0 control, 1 status, 2 data |
| bus_wdata | input | 8 | CPU write data |
| bus_rdata | output | 8 | Read data for `bus_addr` |
| irq | output | 1 | Completion interrupt |
| ss_in | input | 1 | Select pin input, active low |
| sclk_in | input | 1 | Serial clock from the pad (slave) |
| sclk_out | output | 1 | Serial clock to the pad (master) |
| sclk_oe | output | 1 | Serial clock output enable |
| mosi_in | input | 1 | Master-out line from the pad (slave) |
| mosi_out | output | 1 | Master-out value (master) |
| mosi_oe | output | 1 | Master-out output enable |
| miso_in | input | 1 | Slave-out line from the pad (master) |
| miso_out | output | 1 | Slave-out value (slave) |
| miso_oe | output | 1 | Slave-out output enable |

## Verification
If the edge counter or phase decode is wrong, it shows at the ports within one byte. A shifted or lost bit turns up in the byte captured on `mosi_out`, or in the byte read back from address 2. A wrong divider shows as a first SCLK edge arriving at the wrong cycle after the start write. A stale role bit shows within three cycles of a select change, as a wrong output enable or as control bit 2 failing to clear. A broken collision guard shows on the next exchange, because the slave then shifts out the colliding byte instead of the protected one.

// File: rtl/spi_duplex_pkg.sv
package spi_duplex_pkg;
    localparam int BYTE_W  = 8;
    localparam int DIV_W   = 2;
    localparam int EDGE_W  = $clog2(2 * BYTE_W);
    localparam int BIT_W   = $clog2(BYTE_W);

    localparam logic [1:0] ADDR_CTRL = 2'd0;
    localparam logic [1:0] ADDR_STAT = 2'd1;
    localparam logic [1:0] ADDR_DATA = 2'd2;

    // Control register layout, most significant field first.
    typedef struct packed {
        logic             irq_en;
        logic [DIV_W-1:0] div_sel;
        logic             cpol;
        logic             cpha;
        logic             master;
        logic             ign_sel;
        logic             en;
    } ctrl_t;

    typedef struct packed {
        ctrl_t              ctrl;
        logic               done;
        logic               wcol;
        logic [BYTE_W-1:0]  data;
        logic [BYTE_W-1:0]  tx;
        logic [BYTE_W-1:0]  rx;
        logic               busy;
        logic               sclk;
        logic [EDGE_W-1:0]  edge_cnt;
        logic [BIT_W-1:0]   sbit;
        logic               sclk_prev;
    } eng_t;
endpackage

// File: rtl/spi_in_sync.sv
module spi_in_sync #(
    parameter int               WIDTH   = 1,
    parameter int               STAGES  = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d_in,
    output logic [WIDTH-1:0] d_out
);
    logic [WIDTH-1:0] stage_d [STAGES];
    logic [WIDTH-1:0] stage_q [STAGES];

    always_comb begin
        stage_d[0] = d_in;
        for (int i = 1; i < STAGES; i++) begin
            stage_d[i] = stage_q[i-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) begin
                stage_q[i] <= RST_VAL;
            end
        end else begin
            for (int i = 0; i < STAGES; i++) begin
                stage_q[i] <= stage_d[i];
            end
        end
    end

    assign d_out = stage_q[STAGES-1];
endmodule

// File: rtl/spi_tick_gen.sv
module spi_tick_gen #(
    parameter int DIV_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [DIV_W-1:0] div_sel,
    output logic             tick
);
    localparam int CNT_W = (1 << DIV_W) + 1;

    logic [CNT_W-1:0] cnt_d, cnt_q;
    logic [CNT_W-1:0] half_m1;

    always_comb begin
        half_m1 = (CNT_W'(2) << div_sel) - CNT_W'(1);
        tick    = run && (cnt_q >= half_m1);
        if (!run || tick) begin
            cnt_d = '0;
        end else begin
            cnt_d = cnt_q + CNT_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    AST_TICK_GAP: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !tick); // R6
endmodule

// File: rtl/spi_duplex_ctrl.sv
module spi_duplex_ctrl
    import spi_duplex_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic [1:0]        bus_addr,
    input  logic [BYTE_W-1:0] bus_wdata,
    output logic [BYTE_W-1:0] bus_rdata,
    output logic              irq,
    input  logic              ss_in,
    input  logic              sclk_in,
    output logic              sclk_out,
    output logic              sclk_oe,
    input  logic              mosi_in,
    output logic              mosi_out,
    output logic              mosi_oe,
    input  logic              miso_in,
    output logic              miso_out,
    output logic              miso_oe
);
    localparam logic [EDGE_W-1:0] LAST_EDGE = EDGE_W'(2 * BYTE_W - 1);
    localparam logic [BIT_W-1:0]  LAST_BIT  = BIT_W'(BYTE_W - 1);

    eng_t st_d, st_q;

    logic [2:0] sync_out;
    logic       ss_s, sclk_s, mosi_s;
    logic       tick;

    spi_in_sync #(
        .WIDTH  (3),
        .STAGES (SYNC_STAGES),
        .RST_VAL(3'b100)
    ) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .d_in ({ss_in, sclk_in, mosi_in}),
        .d_out(sync_out)
    );

    assign {ss_s, sclk_s, mosi_s} = sync_out;

    spi_tick_gen #(
        .DIV_W(DIV_W)
    ) u_tick (
        .clk    (clk),
        .rst_n  (rst_n),
        .run    (st_q.busy),
        .div_sel(st_q.ctrl.div_sel),
        .tick   (tick)
    );

    logic wr_ctrl, wr_stat, wr_data;
    logic is_master, is_slave, slv_sel, slv_busy, fault;
    logic lead, sample;

    always_comb begin
        st_d = st_q;

        wr_ctrl = bus_wr && (bus_addr == ADDR_CTRL);
        wr_stat = bus_wr && (bus_addr == ADDR_STAT);
        wr_data = bus_wr && (bus_addr == ADDR_DATA);

        is_master = st_q.ctrl.en && st_q.ctrl.master;
        is_slave  = st_q.ctrl.en && !st_q.ctrl.master;
        slv_sel   = st_q.ctrl.ign_sel || !ss_s;
        slv_busy  = slv_sel && (!st_q.ctrl.cpha || (st_q.sbit != '0));
        fault     = is_master && !st_q.ctrl.ign_sel && !ss_s;
        lead      = (sclk_s != st_q.ctrl.cpol);
        sample    = lead ^ st_q.ctrl.cpha;

        // Register writes
        if (wr_ctrl) begin
            st_d.ctrl = ctrl_t'(bus_wdata);
        end
        if (wr_stat) begin
            if (bus_wdata[0]) st_d.done = 1'b0;
            if (bus_wdata[1]) st_d.wcol = 1'b0;
        end

        // Master shift engine, one step per half bit
        if (st_q.busy && tick) begin
            st_d.sclk     = !st_q.sclk;
            st_d.edge_cnt = st_q.edge_cnt + EDGE_W'(1);
            if (st_q.edge_cnt[0] == st_q.ctrl.cpha) begin
                st_d.rx = {st_q.rx[BYTE_W-2:0], miso_in};
            end else if (!(st_q.ctrl.cpha && st_q.edge_cnt == '0)) begin
                st_d.tx = {st_q.tx[BYTE_W-2:0], 1'b0};
            end
            if (st_q.edge_cnt == LAST_EDGE) begin
                st_d.busy = 1'b0;
                st_d.done = 1'b1;
                st_d.data = st_d.rx;
            end
        end

        // Slave shift engine on synchronised pad edges
        st_d.sclk_prev = sclk_s;
        if (!is_slave || !slv_sel) begin
            st_d.sbit = '0;
        end else if (sclk_s != st_q.sclk_prev) begin
            if (sample) begin
                st_d.rx   = {st_q.rx[BYTE_W-2:0], mosi_s};
                st_d.sbit = st_q.sbit + BIT_W'(1);
                if (st_q.sbit == LAST_BIT) begin
                    st_d.done = 1'b1;
                    st_d.data = st_d.rx;
                end
            end else if (!(st_q.ctrl.cpha && st_q.sbit == '0)) begin
                st_d.tx = {st_q.tx[BYTE_W-2:0], 1'b0};
            end
        end

        // Data register write: start, load or collide
        if (wr_data) begin
            if (is_master) begin
                if (st_q.busy) begin
                    st_d.wcol = 1'b1;
                end else begin
                    st_d.tx       = bus_wdata;
                    st_d.rx       = '0;
                    st_d.busy     = 1'b1;
                    st_d.edge_cnt = '0;
                end
            end else if (is_slave && slv_busy) begin
                st_d.wcol = 1'b1;
            end else if (is_slave) begin
                st_d.tx = bus_wdata;
            end
        end

        // Mode fault: another master owns the bus
        if (fault) begin
            st_d.ctrl.master = 1'b0;
            st_d.busy        = 1'b0;
            st_d.edge_cnt    = '0;
        end

        if (!st_d.busy) begin
            st_d.sclk = st_d.ctrl.cpol;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    // Pin and bus outputs
    always_comb begin
        sclk_out = st_q.sclk;
        mosi_out = st_q.tx[BYTE_W-1];
        miso_out = st_q.tx[BYTE_W-1];
        sclk_oe  = is_master && (st_q.ctrl.ign_sel || st_q.busy);
        mosi_oe  = is_master && (st_q.ctrl.ign_sel || st_q.busy);
        miso_oe  = is_slave && (st_q.ctrl.ign_sel || !ss_in);
        irq      = st_q.ctrl.irq_en && st_q.done;
        case (bus_addr)
            ADDR_CTRL: bus_rdata = st_q.ctrl;
            ADDR_STAT: bus_rdata = {{(BYTE_W-2){1'b0}}, st_q.wcol, st_q.done};
            ADDR_DATA: bus_rdata = st_q.data;
            default:   bus_rdata = '0;
        endcase
    end

    AST_MODE_FAULT: assert property (@(posedge clk) disable iff (!rst_n)
        (is_master && !st_q.ctrl.ign_sel && !ss_s) |=> !st_q.ctrl.master); // R3

    AST_SCLK_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !st_q.busy |-> (st_q.sclk == st_q.ctrl.cpol)); // R4

    AST_DONE_ON_FINISH: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(st_q.busy) && st_q.ctrl.master) |-> st_q.done); // R8

    AST_SLAVE_WCOL: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_data && is_slave && slv_sel && !st_q.ctrl.cpha) |=> st_q.wcol); // R9

    AST_DONE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.done && !(wr_stat && bus_wdata[0])) |=> st_q.done); // R11

    AST_MASTER_WCOL: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_data && is_master && st_q.busy && !fault) |=> (st_q.wcol && st_q.busy)); // R12
endmodule

// File: tb/spi_duplex_ctrl_tb.sv
module spi_duplex_ctrl_tb;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bus_wr = 1'b0;
    logic [1:0] bus_addr = 2'd0;
    logic [7:0] bus_wdata = 8'd0;
    logic [7:0] bus_rdata;
    logic       irq;
    logic       ss_in = 1'b1, sclk_in = 1'b0, mosi_in = 1'b0, miso_in = 1'b0;
    logic       sclk_out, sclk_oe, mosi_out, mosi_oe, miso_out, miso_oe;

    int n_chk = 0;
    int n_err = 0;

    always #(CLK_PERIOD/2) clk = !clk;

    spi_duplex_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq),
        .ss_in(ss_in), .sclk_in(sclk_in), .sclk_out(sclk_out), .sclk_oe(sclk_oe),
        .mosi_in(mosi_in), .mosi_out(mosi_out), .mosi_oe(mosi_oe),
        .miso_in(miso_in), .miso_out(miso_out), .miso_oe(miso_oe)
    );

    typedef struct packed {
        logic       cpol;
        logic       cpha;
        logic [1:0] div;
        logic [7:0] tx;
        logic [7:0] pat;
    } vec_t;

    localparam int N_VEC = 4;
    localparam vec_t VECS [N_VEC] = '{
        '{cpol:1'b0, cpha:1'b0, div:2'd0, tx:8'hA5, pat:8'h3C},
        '{cpol:1'b0, cpha:1'b1, div:2'd1, tx:8'h5A, pat:8'hC3},
        '{cpol:1'b1, cpha:1'b0, div:2'd2, tx:8'hF0, pat:8'h0F},
        '{cpol:1'b1, cpha:1'b1, div:2'd3, tx:8'h81, pat:8'h7E}
    };

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [7:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic wait_sclk(output int n);
        logic p;
        p = sclk_out;
        n = 0;
        while (sclk_out == p && n < 2000) begin
            @(negedge clk);
            n++;
        end
    endtask

    task automatic run_master(input vec_t v);
        logic [7:0] cap, r;
        int n, k;
        ss_in = 1'b1;
        wr(2'd0, {1'b1, v.div, v.cpol, v.cpha, 3'b101});
        wr(2'd1, 8'h03);
        cap = 8'h00;
        k = v.cpha ? 0 : 1;
        miso_in = v.cpha ? 1'b0 : v.pat[7];
        wr(2'd2, v.tx);
        chk("R4 mosi_oe while shifting", mosi_oe, 1);
        wait_sclk(n);
        chk("R6 first edge delay", n, 2 << v.div);
        for (int e = 0; e < 16; e++) begin
            if (e % 2 == int'(v.cpha)) begin
                cap = {cap[6:0], mosi_out};
            end else if (k < 8) begin
                miso_in = v.pat[7-k];
                k++;
            end
            if (e < 15) begin
                wait_sclk(n);
                if (e == 0) chk("R6 half period", n, 2 << v.div);
            end
        end
        chk("R7 master sent byte", cap, v.tx);
        rd(2'd2, r);
        chk("R7 master received byte", r, v.pat);
        rd(2'd1, r);
        chk("R8 done flag", r[0], 1);
        chk("R8 irq", irq, 1);
        chk("R4 sclk_oe released", sclk_oe, 0);
        chk("R4 sclk idle level", sclk_out, v.cpol);
    endtask

    task automatic slave_xfer(input logic cpol, input logic cpha, input logic [7:0] mo,
                              output logic [7:0] got);
        int hp;
        hp = 8;
        got = 8'h00;
        if (!cpha) begin
            mosi_in = mo[7];
            repeat (hp) @(negedge clk);
            for (int i = 0; i < 8; i++) begin
                got = {got[6:0], miso_out};
                sclk_in = !cpol;
                repeat (hp) @(negedge clk);
                sclk_in = cpol;
                repeat (3) @(negedge clk);
                if (i < 7) mosi_in = mo[6-i];
                repeat (hp - 3) @(negedge clk);
            end
        end else begin
            for (int i = 0; i < 8; i++) begin
                sclk_in = !cpol;
                repeat (3) @(negedge clk);
                mosi_in = mo[7-i];
                repeat (hp - 3) @(negedge clk);
                got = {got[6:0], miso_out};
                sclk_in = cpol;
                repeat (hp) @(negedge clk);
            end
        end
        repeat (4) @(negedge clk);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_err++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        logic [7:0] r, got;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // Reset state
        rd(2'd0, r); chk("R1 reset ctrl", r, 0);
        rd(2'd1, r); chk("R1 reset status", r, 0);
        chk("R1 reset oe", {sclk_oe, mosi_oe, miso_oe, irq}, 0);

        // Disabled: master bit set but enable clear
        ss_in = 1'b0;
        wr(2'd0, 8'h04);
        wr(2'd2, 8'h55);
        repeat (100) @(negedge clk);
        chk("R1 disabled oe", {sclk_oe, mosi_oe, miso_oe}, 0);
        rd(2'd1, r); chk("R1 disabled no flag", r, 0);
        ss_in = 1'b1;

        // Vector table of master transfers
        for (int i = 0; i < N_VEC; i++) begin
            run_master(VECS[i]);
        end

        // Sticky flags, write-one-to-clear
        wr(2'd1, 8'h02);
        rd(2'd1, r); chk("R11 done kept on other bit", r[0], 1);
        wr(2'd1, 8'h01);
        rd(2'd1, r); chk("R11 done cleared", r[0], 0);
        chk("R8 irq follows flag", irq, 0);

        // Master write while busy
        wr(2'd0, 8'hE5);
        wr(2'd2, 8'h11);
        repeat (10) @(negedge clk);
        wr(2'd2, 8'h22);
        rd(2'd1, r); chk("R12 collision flag", r[1], 1);
        chk("R12 transfer continues", sclk_oe, 1);
        repeat (400) @(negedge clk);
        rd(2'd1, r); chk("R12 first transfer completes", r[0], 1);
        wr(2'd1, 8'h03);

        // Mode fault
        wr(2'd0, 8'h05);
        ss_in = 1'b0;
        repeat (4) @(negedge clk);
        rd(2'd0, r); chk("R3 master bit cleared", r[2], 0);
        chk("R3 now slave driving miso", {miso_oe, mosi_oe, sclk_oe}, 3'b100);
        ss_in = 1'b1;

        // Ignore-select roles
        wr(2'd0, 8'h07);
        ss_in = 1'b0;
        repeat (5) @(negedge clk);
        rd(2'd0, r); chk("R5 master kept with select ignored", r[2], 1);
        chk("R5 master drives idle", {mosi_oe, sclk_oe, miso_oe}, 3'b110);
        ss_in = 1'b1;
        wr(2'd0, 8'h03);
        repeat (3) @(negedge clk);
        chk("R5 slave drives with ss high", miso_oe, 1);

        // Slave with select honoured
        wr(2'd0, 8'h01);
        #1; chk("R2 miso released ss high", miso_oe, 0);
        ss_in = 1'b0;
        #1; chk("R2 miso driven ss low", miso_oe, 1);
        ss_in = 1'b1;

        // Slave phase 0: collision protects loaded byte
        sclk_in = 1'b0;
        wr(2'd1, 8'h03);
        wr(2'd2, 8'h96);
        ss_in = 1'b0;
        repeat (4) @(negedge clk);
        wr(2'd2, 8'h3C);
        rd(2'd1, r); chk("R9 collision flag", r[1], 1);
        slave_xfer(1'b0, 1'b0, 8'h5B, got);
        chk("R9 loaded byte unchanged", got, 8'h96);
        rd(2'd2, r); chk("R7 slave phase0 received", r, 8'h5B);
        rd(2'd1, r); chk("R7 slave phase0 done", r[0], 1);
        ss_in = 1'b1;
        repeat (4) @(negedge clk);

        // Slave phase 1, polarity 1, select held low over two bytes
        sclk_in = 1'b1;
        wr(2'd0, 8'h19);
        wr(2'd1, 8'h03);
        wr(2'd2, 8'hC6);
        ss_in = 1'b0;
        repeat (4) @(negedge clk);
        slave_xfer(1'b1, 1'b1, 8'h71, got);
        chk("R10 first byte sent", got, 8'hC6);
        rd(2'd2, r); chk("R10 first byte received", r, 8'h71);
        rd(2'd1, r); chk("R10 first byte done", r[0], 1);
        wr(2'd1, 8'h01);
        wr(2'd2, 8'h2D);
        rd(2'd1, r); chk("R10 no collision between bytes", r, 0);
        slave_xfer(1'b1, 1'b1, 8'hE4, got);
        chk("R10 second byte sent", got, 8'h2D);
        rd(2'd2, r); chk("R10 second byte received", r, 8'hE4);
        rd(2'd1, r); chk("R10 second byte done", r[0], 1);
        ss_in = 1'b1;

        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule